// File: doc/BRIEF.md
# Per-Channel Tristate Control Serializer

This block produces four serial control lines. Together they carry one high-impedance control bit for every channel of sixteen time-division-multiplexed output streams. It runs on a 16.384 MHz bit clock, and a frame holds 2048 bit periods. The gated data streams run at twice that rate, with 512 channels each. External bus buffers use these lines to switch a data stream's drivers ahead of the data they gate.

Each control line interleaves four streams that are spaced four apart. Within every group of four periods, line k sends the bit for one channel of stream k, then of stream k+4, then k+8, then k+12. The whole sequence is advanced by five periods, so channel 0 of stream 0 leaves in period 2043 and the sequence wraps across the frame boundary.

The bits come from an external control store through a synchronous read port with one cycle of latency. One read returns a word holding the bits of all four lines for one period. The block issues each read one period before the bit is due.

The sequencing is a two-state machine:
- ST_IDLE: the state after reset. The lines drive 0 and no read is issued. The machine stays in ST_IDLE until the first frame pulse.
- ST_RUN: entered on the edge that samples the first frame pulse. The machine never leaves it. A later frame pulse only realigns the period counter.

Top module: `tristate_ctl_serializer`

## Requirements
- R1: After reset, and for as long as no frame pulse has been sampled, every bit of `ctl_out` is 0 and `rd_en` is 0.
- R2: A `frame_pulse` sampled high on a clock edge makes the next cycle period 0 and moves the machine from ST_IDLE to ST_RUN. The machine then stays in ST_RUN.
- R3: With no frame pulse, the period advances by one per cycle and wraps from 2047 to 0 by itself.
- R4: In period p, line k carries the bit of stream 4g+k, channel n, where 4n+g = (p+5) mod 2048.
- R5: The channel 0 bit of stream 0 leaves on line 0 in period 2043. The channel 0 bits of streams 12, 13, 14 and 15 leave on lines 0, 1, 2 and 3 in period 2046.
- R6: The bit of stream 4, channel 510 leaves on line 0 in period 2036. The bit of stream 5, channel 4 leaves on line 1 in period 12.
- R7: `rd_addr` is the slot index 4n+g, with the channel in the upper nine bits and the group g in the lower two. Bit k of the returned word is the bit of stream 4g+k. The word returned in the cycle after the address is the one put on `ctl_out`.
- R8: While reading, `rd_addr` steps by one per cycle modulo 2048. In a cycle with `frame_pulse` high, `rd_addr` is 5, which is the slot for period 0.
- R9: A frame pulse in the middle of a frame realigns the sequence, and the cycle after it already carries the bits of period 0.
- R10: A control bit of 1 (drive the channel) appears as 1 and a bit of 0 (high impedance) as 0, with no inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | High in the last period of a frame; sampled on the clock edge |
| rd_en | output | 1 | Read strobe to the control store |
| rd_addr | output | 11 | Slot index {channel, group} of the period that follows |
| rd_data | input | 4 | Control word returned one cycle after the read; bit k belongs to line k |
| ctl_out | output | 4 | Serial control lines, one bit per period each |

## Verification
The assertions check on every cycle:
- the counter's wrap and its reset by the frame pulse;
- the one-way transition from ST_IDLE to ST_RUN;
- the silence in ST_IDLE;
- the one-per-cycle address step, and the forced slot address in a pulse cycle.

Only the bench's scenarios can show that each output bit belongs to the right stream and channel. This needs a behavioural store filled with a stream- and channel-dependent pattern, and a period model. The bench's scenarios cover two framed frames, a free-running wrap, a mid-frame realignment and the named corner periods.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    // Sequencing states of the serializer
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tsc_state_e;

endpackage

// File: rtl/tsc_period_counter.sv
module tsc_period_counter #(
    parameter int PERIODS = 2048,
    localparam int AW = $clog2(PERIODS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_pulse,
    output logic [AW-1:0] period_q
);

    localparam logic [AW-1:0] LAST = AW'(PERIODS - 1);

    // Frame pulse forces period 0 next; otherwise count and wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (frame_pulse) begin
            period_q <= '0;
        end else if (period_q == LAST) begin
            period_q <= '0;
        end else begin
            period_q <= period_q + AW'(1);
        end
    end

endmodule

// File: rtl/tsc_slot_mapper.sv
module tsc_slot_mapper #(
    parameter int PERIODS = 2048,
    parameter int LEAD    = 5,
    localparam int AW = $clog2(PERIODS)
) (
    input  logic [AW-1:0] period_q,
    input  logic          frame_pulse,
    output logic [AW-1:0] slot_addr
);

    // Slot needed in the coming period: that period's number plus the lead, modulo the frame
    int unsigned nxt;
    int unsigned sum;

    always_comb begin
        if (frame_pulse) begin
            nxt = 0;
        end else if (int'(period_q) == PERIODS - 1) begin
            nxt = 0;
        end else begin
            nxt = int'(period_q) + 1;
        end
        sum = nxt + LEAD;
        if (sum >= PERIODS) begin
            sum = sum - PERIODS;
        end
        slot_addr = AW'(sum);
    end

endmodule

// File: rtl/tsc_lane_gate.sv
module tsc_lane_gate (
    input  logic enable,
    input  logic ctl_bit,
    output logic ctl_line
);

    // A line stays at 0 (high impedance) until sequencing is running
    always_comb begin
        ctl_line = enable & ctl_bit;
    end

endmodule

// File: rtl/tristate_ctl_serializer.sv
module tristate_ctl_serializer
    import tsc_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int GROUPS   = 4,
    parameter int CHANNELS = 512,
    parameter int LEAD     = 5,
    localparam int PERIODS = CHANNELS * GROUPS,
    localparam int AW      = $clog2(PERIODS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [LANES-1:0] rd_data,
    output logic [LANES-1:0] ctl_out
);

    tsc_state_e    state_q;
    tsc_state_e    state_d;
    logic          lanes_en;
    logic [AW-1:0] period_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (frame_pulse) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        rd_en    = 1'b0;
        lanes_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rd_en    = frame_pulse;
                lanes_en = 1'b0;
            end
            ST_RUN: begin
                rd_en    = 1'b1;
                lanes_en = 1'b1;
            end
            default: begin
                rd_en    = 1'b0;
                lanes_en = 1'b0;
            end
        endcase
    end

    tsc_period_counter #(
        .PERIODS (PERIODS)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .period_q    (period_q)
    );

    tsc_slot_mapper #(
        .PERIODS (PERIODS),
        .LEAD    (LEAD)
    ) u_mapper (
        .period_q    (period_q),
        .frame_pulse (frame_pulse),
        .slot_addr   (rd_addr)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        tsc_lane_gate u_gate (
            .enable   (lanes_en),
            .ctl_bit  (rd_data[i]),
            .ctl_line (ctl_out[i])
        );
    end

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
    import tsc_pkg::*;
#(
    parameter int PERIODS = 2048,
    parameter int LEAD    = 5,
    parameter int LANES   = 4,
    localparam int AW = $clog2(PERIODS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_pulse,
    input logic             rd_en,
    input logic [AW-1:0]    rd_addr,
    input logic [LANES-1:0] ctl_out,
    input logic [AW-1:0]    period_q,
    input tsc_state_e       state_q
);

    localparam logic [AW-1:0] LAST     = AW'(PERIODS - 1);
    localparam logic [AW-1:0] LEAD_ADR = AW'(LEAD);

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == LAST && !frame_pulse) |=> (period_q == '0)); // R3

    AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (period_q == '0)); // R2

    AST_FIRST_PULSE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && frame_pulse) |=> (state_q == ST_RUN)); // R2

    AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frame_pulse) |-> (ctl_out == '0 && !rd_en)); // R1

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && rd_en && !frame_pulse) |-> (rd_addr == $past(rd_addr) + AW'(1))); // R8

    AST_PULSE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> (rd_en && rd_addr == LEAD_ADR)); // R8

endmodule

bind tristate_ctl_serializer tsc_checker #(
    .PERIODS (PERIODS),
    .LEAD    (LEAD),
    .LANES   (LANES)
) u_tsc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .ctl_out     (ctl_out),
    .period_q    (period_q),
    .state_q     (state_q)
);

// File: tb/tristate_ctl_serializer_bench.sv
module tristate_ctl_serializer_bench;

    localparam int CLK_PERIOD = 60;
    localparam int PERIODS    = 2048;
    localparam int LANES      = 4;
    localparam int LEAD       = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_pulse = 1'b0;
    logic        rd_en;
    logic [10:0] rd_addr;
    logic [3:0]  rd_data;
    logic [3:0]  ctl_out;

    int    checks = 0;
    int    failures = 0;
    bit    started = 1'b0;
    string tag = "R1";

    bit [3:0] mem [PERIODS];

    // Model state: current period and whether sequencing has started
    int mp = 0;
    bit mact = 1'b0;

    tristate_ctl_serializer u_tristate_ctl_serializer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .ctl_out     (ctl_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit ctl_bit(int s, int n);
        return ((s * 37 + n * 11 + (n >> 2)) % 7) < 3;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at period %0d: actual=%0h expected=%0h", req, mp, act, exp);
        end
    endtask

    // Behavioural control store with one cycle of read latency
    always @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

    // Period model
    always @(posedge clk) begin
        if (!rst_n) begin
            mp   <= 0;
            mact <= 1'b0;
        end else if (frame_pulse) begin
            mp   <= 0;
            mact <= 1'b1;
        end else begin
            mp <= (mp + 1) % PERIODS;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #2;
        if (started && rst_n) begin
            bit       exp_en;
            int       slot;
            int       ch;
            int       grp;
            int       exp_addr;
            bit [3:0] exp_out;
            exp_en = mact || frame_pulse;
            check(rd_en == exp_en, "R1,R8 rd_en", int'(rd_en), int'(exp_en));
            if (exp_en) begin
                exp_addr = ((frame_pulse ? 0 : (mp + 1) % PERIODS) + LEAD) % PERIODS;
                check(int'(rd_addr) == exp_addr, "R7,R8 rd_addr", int'(rd_addr), exp_addr);
            end
            slot = (mp + LEAD) % PERIODS;
            ch   = slot / 4;
            grp  = slot % 4;
            for (int k = 0; k < LANES; k++) begin
                exp_out[k] = mact ? ctl_bit(4 * grp + k, ch) : 1'b0;
            end
            check(ctl_out == exp_out, {tag, ",R4,R10 ctl_out"}, int'(ctl_out), int'(exp_out));
            if (mact) begin
                if (mp == 2043) check(ctl_out[0] == ctl_bit(0, 0), "R5 s0 c0", int'(ctl_out[0]), int'(ctl_bit(0, 0)));
                if (mp == 2046) begin
                    for (int k = 0; k < LANES; k++) begin
                        check(ctl_out[k] == ctl_bit(12 + k, 0), "R5 s12..15 c0", int'(ctl_out[k]), int'(ctl_bit(12 + k, 0)));
                    end
                end
                if (mp == 2036) check(ctl_out[0] == ctl_bit(4, 510), "R6 s4 c510", int'(ctl_out[0]), int'(ctl_bit(4, 510)));
                if (mp == 12)   check(ctl_out[1] == ctl_bit(5, 4), "R6 s5 c4", int'(ctl_out[1]), int'(ctl_bit(5, 4)));
                if (mp == 2039) check(ctl_out[0] == ctl_bit(0, 511), "R4 s0 c511", int'(ctl_out[0]), int'(ctl_bit(0, 511)));
                if (mp == 2047) check(ctl_out[0] == ctl_bit(0, 1), "R4 s0 c1", int'(ctl_out[0]), int'(ctl_bit(0, 1)));
            end
        end
    end

    task automatic wait_period(int x);
        do @(negedge clk); while (mp != x);
    endtask

    task automatic pulse();
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
    endtask

    initial begin
        for (int n = 0; n < PERIODS / 4; n++) begin
            for (int g = 0; g < 4; g++) begin
                for (int k = 0; k < LANES; k++) begin
                    mem[n * 4 + g][k] = ctl_bit(4 * g + k, n);
                end
            end
        end
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        #2;
        check(ctl_out == 4'h0, "R1 reset ctl_out", int'(ctl_out), 0);
        check(rd_en == 1'b0, "R1 reset rd_en", int'(rd_en), 0);
        rst_n = 1'b1;
        started = 1'b1;
        tag = "R1";
        repeat (100) @(negedge clk);
        tag = "R2";
        pulse();
        wait_period(2047);
        tag = "R4";
        pulse();
        wait_period(2047);
        pulse();
        wait_period(2047);
        tag = "R3";
        wait_period(1000);
        tag = "R9";
        pulse();
        repeat (2200) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule